// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a small first-in first-out byte store that decouples an instruction fetch engine from an instruction decoder. While the decoder works through earlier bytes, the fetch side keeps filling the queue with opcode bytes. It can deliver one byte or a pair of bytes per beat, so memory traffic overlaps execution. The decoder sees the oldest byte at the head and removes bytes one at a time. With each removal it says whether that byte starts a new instruction or continues the current one.

A flush input throws away everything held, as needed after a jump or any other control transfer. A two-bit status code, registered, tells the outside what the queue did in the previous clock cycle:

- 00: idle.
- 01: the first byte of an opcode was popped.
- 11: a following byte of the same instruction was popped.
- 10: the queue was flushed.

A prefetch request output tells the fetch engine that a full two-byte word would fit.

Top module: `prefetch_queue`

## Requirements
- R1: After reset `fillLevel` is 0, `popValid` is 0, `qStatus` is 00 and `fetchReq` is 1.
- R2: The queue holds up to 6 bytes and returns them in the order they were accepted. `popValid` is 1 exactly when `fillLevel` is non-zero, and `popData` then shows the oldest byte.
- R3: A push with `pushTwo`=1 stores `pushData[7:0]` ahead of `pushData[15:8]`. A push with `pushTwo`=0 stores only `pushData[7:0]`.
- R4: A one-byte push needs at least one free slot, and a two-byte push needs at least two. Free slots are counted before any pop in the same cycle. A push without that room is dropped whole, and level and contents stay unchanged.
- R5: `fetchReq` is 1 exactly when at least two slots are free, that is when `fillLevel` is 4 or less.
- R6: A pop on a non-empty queue removes the head byte. In the next cycle `qStatus` reads 01 when `popFirst` was 1 and 11 when `popFirst` was 0.
- R7: In a cycle with neither a flush nor an accepted pop, `qStatus` reads 00 in the next cycle, even when bytes were pushed.
- R8: `flush` empties the queue and overrides any push or pop in the same cycle. In the next cycle `fillLevel` is 0 and `qStatus` reads 10.
- R9: A pop request on an empty queue is ignored. The level does not change and the next `qStatus` is 00.
- R10: A push and a pop in the same cycle both take effect. The level moves by the number of bytes pushed minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Fetch side offers bytes this cycle |
| pushTwo | input | 1 | 1: two bytes offered, 0: one byte |
| pushData | input | 16 | Offered bytes, low byte is older |
| flush | input | 1 | Discard all held bytes |
| popReq | input | 1 | Decoder takes the head byte |
| popFirst | input | 1 | The taken byte starts an instruction |
| popValid | output | 1 | Head byte is valid |
| popData | output | 8 | Head byte |
| fillLevel | output | 3 | Bytes currently held |
| fetchReq | output | 1 | Room for a two-byte word |
| qStatus | output | 2 | Operation performed in the previous cycle |

## Verification
The bench fills the queue to exactly six bytes and offers one more byte. A design with an off-by-one full test would accept that byte and overwrite the oldest entry. It also offers a byte pair at five held bytes, where a design that half-accepts the pair would leave a stray low byte. Flushes are issued together with a push and a pop, to catch a design that lets the push land after the clear or reports a pop status. Pops on an empty queue catch a design that reports 01 or 11 or lets the level wrap. Read and write pointers cross the six-slot wrap point many times, so a design that wraps at a power of two returns bytes out of order.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Per-cycle operation code shown on qStatus.
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qStatus_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic wrOne;   // store low byte
    logic wrTwo;   // store low then high byte
    logic rdOne;   // retire head byte
    logic clear;   // reset both pointers
  } qStrobe_t;

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int REQ_FREE = 2,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             pushTwo,
  input  logic             popReq,
  input  logic             popFirst,
  input  logic             flush,
  output qStrobe_t         strobe,
  output logic [CNT_W-1:0] fillLevel,
  output logic             popValid,
  output logic             fetchReq,
  output logic [1:0]       qStatus
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] REQ_C   = CNT_W'(REQ_FREE);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);

  logic [CNT_W-1:0] countQ, countNext, freeSlots;
  qStatus_e         statusQ, statusNext;
  logic             pushOk, popOk;

  // Room is judged on the level at the start of the cycle.
  assign freeSlots = DEPTH_C - countQ;
  assign pushOk    = pushValid && (pushTwo ? (freeSlots >= TWO_C) : (freeSlots != '0));
  assign popOk     = popReq && (countQ != '0);

  always_comb begin
    strobe.clear = flush;
    strobe.wrOne = !flush && pushOk && !pushTwo;
    strobe.wrTwo = !flush && pushOk && pushTwo;
    strobe.rdOne = !flush && popOk;
  end

  always_comb begin
    if (flush) begin
      countNext = '0;
    end else begin
      countNext = countQ;
      if (strobe.wrOne) countNext = countNext + ONE_C;
      if (strobe.wrTwo) countNext = countNext + TWO_C;
      if (strobe.rdOne) countNext = countNext - ONE_C;
    end
  end

  always_comb begin
    if (flush)      statusNext = QS_FLUSH;
    else if (popOk) statusNext = popFirst ? QS_FIRST : QS_NEXT;
    else            statusNext = QS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      statusQ <= QS_IDLE;
    end else begin
      countQ  <= countNext;
      statusQ <= statusNext;
    end
  end

  assign fillLevel = countQ;
  assign popValid  = (countQ != '0);
  assign fetchReq  = (freeSlots >= REQ_C);
  assign qStatus   = statusQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= DEPTH_C); // R4

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (countQ == '0) && (statusQ == QS_FLUSH)); // R8

  AST_POP_HAD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[0] |-> ($past(countQ) != '0)); // R9

  AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !popReq) |=> (statusQ == QS_IDLE)); // R7

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !popReq && !pushValid) |=> $stable(countQ)); // R2

endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  qStrobe_t            strobe,
  input  logic [2*BYTE_W-1:0] pushData,
  output logic [BYTE_W-1:0]   popData
);

  localparam logic [PTR_W:0] DEPTH_W = (PTR_W + 1)'(DEPTH);

  logic [PTR_W-1:0]  wrPtrQ, rdPtrQ, wrPtrPlus1, wrPtrPlus2, rdPtrPlus1;
  logic [BYTE_W-1:0] slotQ [DEPTH];
  logic [BYTE_W-1:0] loByte, hiByte;

  // Advance a pointer by inc slots, wrapping at DEPTH.
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [1:0] inc);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W + 1)'(inc);
    if (s >= DEPTH_W) s = s - DEPTH_W;
    return s[PTR_W-1:0];
  endfunction

  assign wrPtrPlus1 = bump(wrPtrQ, 2'd1);
  assign wrPtrPlus2 = bump(wrPtrQ, 2'd2);
  assign rdPtrPlus1 = bump(rdPtrQ, 2'd1);
  assign loByte     = pushData[BYTE_W-1:0];
  assign hiByte     = pushData[2*BYTE_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
    end else begin
      if (strobe.wrTwo)      wrPtrQ <= wrPtrPlus2;
      else if (strobe.wrOne) wrPtrQ <= wrPtrPlus1;
      if (strobe.rdOne)      rdPtrQ <= rdPtrPlus1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ[g] <= '0;
      end else if ((strobe.wrOne || strobe.wrTwo) && wrPtrQ == IDX) begin
        slotQ[g] <= loByte;
      end else if (strobe.wrTwo && wrPtrPlus1 == IDX) begin
        slotQ[g] <= hiByte;
      end
    end
  end

  assign popData = slotQ[rdPtrQ];

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtrQ < DEPTH_W[PTR_W-1:0] || DEPTH == (1 << PTR_W)) &&
    (rdPtrQ < DEPTH_W[PTR_W-1:0] || DEPTH == (1 << PTR_W))); // R2

  AST_CLEAR_ALIGNS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (rdPtrQ == wrPtrQ)); // R8

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int BYTE_W   = 8,
  parameter int REQ_FREE = 2,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic                pushTwo,
  input  logic [2*BYTE_W-1:0] pushData,
  input  logic                flush,
  input  logic                popReq,
  input  logic                popFirst,
  output logic                popValid,
  output logic [BYTE_W-1:0]   popData,
  output logic [LVL_W-1:0]    fillLevel,
  output logic                fetchReq,
  output logic [1:0]          qStatus
);

  qStrobe_t strobe;

  pfq_ctrl #(
    .DEPTH    (DEPTH),
    .REQ_FREE (REQ_FREE)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushValid (pushValid),
    .pushTwo   (pushTwo),
    .popReq    (popReq),
    .popFirst  (popFirst),
    .flush     (flush),
    .strobe    (strobe),
    .fillLevel (fillLevel),
    .popValid  (popValid),
    .fetchReq  (fetchReq),
    .qStatus   (qStatus)
  );

  pfq_datapath #(
    .DEPTH  (DEPTH),
    .BYTE_W (BYTE_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushData (pushData),
    .popData  (popData)
  );

endmodule

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
module test_prefetch_queue;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pushValid, pushTwo, flush, popReq, popFirst;
  logic [15:0] pushData;
  logic        popValid, fetchReq;
  logic [7:0]  popData;
  logic [2:0]  fillLevel;
  logic [1:0]  qStatus;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference model state.
  logic [7:0] mq[$];
  int         mStatus = 0;

  always #2 clk = ~clk;

  prefetch_queue i_prefetch_queue (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushTwo(pushTwo),
    .pushData(pushData), .flush(flush), .popReq(popReq), .popFirst(popFirst),
    .popValid(popValid), .popData(popData), .fillLevel(fillLevel),
    .fetchReq(fetchReq), .qStatus(qStatus)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare every output with the model.
  task automatic compare(input string lbl);
    string stTag;
    chk(lbl, "fillLevel", int'(fillLevel), mq.size());
    chk("R5", "fetchReq", int'(fetchReq), (6 - mq.size()) >= 2);
    chk(lbl, "popValid", int'(popValid), mq.size() != 0);
    if (mq.size() != 0) chk(lbl, "popData", int'(popData), int'(mq[0]));
    case (mStatus)
      2:       stTag = "R8";
      1, 3:    stTag = "R6";
      default: stTag = "R7";
    endcase
    chk(stTag, "qStatus", int'(qStatus), mStatus);
  endtask

  // Model of one clock edge, from the requirements.
  task automatic modelEdge();
    int  freeNow;
    bit  popOk, pushOk;
    freeNow = 6 - mq.size();
    if (flush) begin
      mq.delete();
      mStatus = 2;
      return;
    end
    popOk  = popReq && mq.size() != 0;
    pushOk = pushValid && (pushTwo ? freeNow >= 2 : freeNow >= 1);
    mStatus = popOk ? (popFirst ? 1 : 3) : 0;
    if (popOk) void'(mq.pop_front());
    if (pushOk) begin
      mq.push_back(pushData[7:0]);
      if (pushTwo) mq.push_back(pushData[15:8]);
    end
  endtask

  task automatic step(input bit pv, input bit p2, input logic [15:0] pd,
                      input bit pr, input bit pf, input bit fl, input string lbl);
    pushValid = pv; pushTwo = p2; pushData = pd;
    popReq = pr; popFirst = pf; flush = fl;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare(lbl);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rstN = 1'b0;
    pushValid = 0; pushTwo = 0; pushData = '0;
    popReq = 0; popFirst = 0; flush = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: fill with single bytes up to the full depth.
    for (int i = 0; i < 6; i++) step(1, 0, 16'h00A0 + 16'(i), 0, 0, 0, "R2");
    // R4: full queue refuses one more byte.
    step(1, 0, 16'h0055, 0, 0, 0, "R4");
    // R6: drain with alternating first/next markers.
    for (int i = 0; i < 6; i++) step(0, 0, '0, 1, (i % 2) == 0, 0, "R6");
    // R9: pop on an empty queue.
    step(0, 0, '0, 1, 1, 0, "R9");
    step(0, 0, '0, 1, 0, 0, "R9");
    // R3: two-byte pushes, low byte first.
    step(1, 1, 16'hB2B1, 0, 0, 0, "R3");
    step(1, 1, 16'hB4B3, 0, 0, 0, "R3");
    step(1, 0, 16'hFFB5, 0, 0, 0, "R3");
    // R4: pair refused with one slot free, single then accepted.
    step(1, 1, 16'hC2C1, 0, 0, 0, "R4");
    step(1, 0, 16'h00C3, 0, 0, 0, "R4");
    // R7: idle cycle with a full queue.
    step(0, 0, '0, 0, 0, 0, "R7");
    // R10: pop and push together.
    step(1, 0, 16'h00D1, 1, 1, 0, "R10");
    step(0, 0, '0, 1, 0, 0, "R10");
    step(1, 1, 16'hD3D2, 1, 0, 0, "R10");
    // R8: flush wins over simultaneous push and pop.
    step(1, 1, 16'hEEEE, 1, 1, 1, "R8");
    step(0, 0, '0, 0, 0, 0, "R7");
    // R5: walk the level across the request threshold.
    for (int i = 0; i < 6; i++) step(1, 0, 16'h0070 + 16'(i), 0, 0, 0, "R5");
    step(0, 0, '0, 0, 0, 1, "R8");

    // R10: mixed traffic crossing the pointer wrap many times.
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[1], {lf[7:0], lf[15:8]} ^ 16'(i), lf[2] | lf[3], lf[4],
           lf[9:5] == 5'd0, "R10");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule